// File: doc/BRIEF.md
# Bit-Matrix and Truth-Table Logic Unit

This block is a 64-bit execution unit for bit-manipulation work. Each accepted operation produces one registered 64-bit result. There are three operations. The first treats one operand as an 8x8 matrix of bits and transposes it. The second applies an arbitrary three-input bitwise function, chosen by an 8-bit truth table given as an immediate. The third applies an arbitrary two-input bitwise function, whose 4-bit truth table is picked at run time from one of the two low nibbles of a third operand.

Bits are numbered from the most significant end: bit 0 is the MSB of a 64-bit value, and the same numbering applies to the truth tables. Index 0 of a table selects its most significant bit.

The three-input function takes the old value of the destination as its first input. The caller therefore presents that value on a separate operand port.

When the record flag is set, the transpose and three-input operations also produce a 4-bit condition summary of the result. The two-input operation never produces one. The result appears one cycle after the input strobe, together with an output strobe.

Top module: `bmlut_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation completes, `out_valid` and `cr_valid` are 0 and `result` and `cr_out` are all zeros.
- R2: `out_valid` is 1 exactly one cycle after each cycle in which `in_valid` is 1, and 0 otherwise. `result` keeps its value in cycles that follow a cycle without `in_valid`.
- R3: With `op` = 0 (transpose), result bit j*8+k equals `src_a` bit k*8+j for j and k from 0 to 7. Bit 0 is the MSB, so MSB-first bit n is vector index 63-n.
- R4: With `op` = 1 (three-input function), result bit i is truth-table bit idx of `tt_imm`, where idx = {`src_d` bit i, `src_a` bit i, `src_b` bit i}. Table bit 0 is `tt_imm[7]`, so the selected bit is `tt_imm[7-idx]`.
- R5: With `op` = 2 (two-input function), the table is MSB-first bits 60..63 of `src_c` (`src_c[3:0]`) when `nh_sel` = 0, and bits 56..59 (`src_c[7:4]`) when `nh_sel` = 1. Result bit i is table bit {`src_a` bit i, `src_b` bit i}, where table bit 0 is the nibble's MSB.
- R6: When `rec_en` = 1 with `op` 0 or 1, `cr_valid` rises together with `out_valid`. `cr_out` = {LT, GT, EQ, SO} is the signed comparison of the new result with zero, with `cr_out[3]` = LT. SO is `so_in` as sampled with the operation.
- R7: An operation with `op` = 2 never raises `cr_valid` and leaves `cr_out` unchanged, even when `rec_en` = 1.
- R8: With `rec_en` = 0, no operation raises `cr_valid` or changes `cr_out`.
- R9: `op` = 3 is reserved. It produces a result of zero with `out_valid`, and it does not raise `cr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 transpose, 1 three-input, 2 two-input, 3 reserved |
| src_d | input | 64 | Old destination value (three-input function) |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source |
| src_c | input | 64 | Table source for the two-input function |
| tt_imm | input | 8 | Three-input truth table |
| nh_sel | input | 1 | Nibble select for the two-input table |
| rec_en | input | 1 | Record flag: request the condition summary |
| so_in | input | 1 | Summary-overflow value copied into SO |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |
| cr_valid | output | 1 | Condition summary strobe |
| cr_out | output | 4 | {LT, GT, EQ, SO} |

## Verification
The hardest condition to reach from the ports is an exact zero result with the record flag set. Random operands almost never cancel to zero, so the EQ flag would go unseen. Directed cases reach it with an all-zero truth table, and with a transpose of zero. The random part of the bench draws every operand bit independently, so each of the eight table indexes occurs at many bit positions within one operation. Every operation also randomises the nibble select and the record flag, which exercises the condition-summary suppression for the two-input function.

// File: rtl/bmlut_unit.sv
module bmlut_unit #(
  parameter int ROWS = 8,
  parameter int TTW  = 8,
  parameter int LUTW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             op,
  input  logic [ROWS*ROWS-1:0]   src_d,
  input  logic [ROWS*ROWS-1:0]   src_a,
  input  logic [ROWS*ROWS-1:0]   src_b,
  input  logic [ROWS*ROWS-1:0]   src_c,
  input  logic [TTW-1:0]         tt_imm,
  input  logic                   nh_sel,
  input  logic                   rec_en,
  input  logic                   so_in,
  output logic                   out_valid,
  output logic [ROWS*ROWS-1:0]   result,
  output logic                   cr_valid,
  output logic [3:0]             cr_out
);
  localparam int W = ROWS * ROWS;
  localparam logic [1:0] OP_XPOSE = 2'd0;
  localparam logic [1:0] OP_TERN  = 2'd1;
  localparam logic [1:0] OP_BIN   = 2'd2;

  logic [W-1:0]      xpose_v, tern_v, bin_v, nxt;
  logic [LUTW-1:0]   lut;
  logic              cr_upd;
  logic              lt, eq;

  assign lut = nh_sel ? src_c[2*LUTW-1:LUTW] : src_c[LUTW-1:0];

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    for (genvar k = 0; k < ROWS; k++) begin : g_col
      assign xpose_v[W-1-(j*ROWS+k)] = src_a[W-1-(k*ROWS+j)];
    end
  end

  for (genvar v = 0; v < W; v++) begin : g_bit
    logic [2:0] t_idx;
    logic [1:0] b_idx;
    assign t_idx    = {src_d[v], src_a[v], src_b[v]};
    assign b_idx    = {src_a[v], src_b[v]};
    assign tern_v[v] = tt_imm[~t_idx];
    assign bin_v[v]  = lut[~b_idx];
  end

  always_comb begin
    case (op)
      OP_XPOSE: nxt = xpose_v;
      OP_TERN:  nxt = tern_v;
      OP_BIN:   nxt = bin_v;
      default:  nxt = '0;
    endcase
  end

  assign cr_upd = in_valid && rec_en && (op == OP_XPOSE || op == OP_TERN);
  assign lt     = nxt[W-1];
  assign eq     = (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cr_valid  <= 1'b0;
      result    <= '0;
      cr_out    <= '0;
    end else begin
      out_valid <= in_valid;
      cr_valid  <= cr_upd;
      if (in_valid) result <= nxt;
      if (cr_upd)   cr_out <= {lt, !lt && !eq, eq, so_in};
    end
  end
endmodule

module bmlut_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic         rec_en,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         cr_valid,
  input logic [3:0]   cr_out
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R6
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> ($countones(cr_out[3:1]) == 1 && out_valid));
  // R6
  cr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> (cr_out[1] == (result == '0) && cr_out[3] == result[W-1]));
  // R7
  bin_no_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2) |=> (!cr_valid && $stable(cr_out)));
  // R8
  norec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rec_en) |=> (!cr_valid && $stable(cr_out)));
  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> (result == '0 && !cr_valid));
endmodule

bind bmlut_unit bmlut_unit_chk #(.W(ROWS*ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rec_en(rec_en),
  .out_valid(out_valid), .result(result), .cr_valid(cr_valid), .cr_out(cr_out)
);

// File: tb/tb_bmlut_unit.sv
module tb_bmlut_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] op = '0;
  logic [63:0] src_d = '0, src_a = '0, src_b = '0, src_c = '0;
  logic [7:0] tt_imm = '0;
  logic nh_sel = 1'b0, rec_en = 1'b0, so_in = 1'b0;
  logic out_valid, cr_valid;
  logic [63:0] result;
  logic [3:0] cr_out;
  int checks = 0, errors = 0;
  logic [3:0] cr_model = '0;
  logic [63:0] res_model = '0;
  bit done = 0;

  bmlut_unit dut (.*);

  always #10 clk = ~clk;

  function automatic logic msb(input logic [63:0] v, input int n);
    return v[63-n];
  endfunction

  function automatic logic [63:0] m_xpose(input logic [63:0] a);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) r[63-(j*8+k)] = msb(a, k*8+j);
    return r;
  endfunction

  function automatic logic [63:0] m_tern(input logic [63:0] d, a, b, input logic [7:0] t);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      int idx = {msb(d,i), msb(a,i), msb(b,i)};
      r[63-i] = t[7-idx];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_bin(input logic [63:0] a, b, c, input logic nh);
    logic [63:0] r = '0;
    int base = nh ? 56 : 60;
    for (int i = 0; i < 64; i++) begin
      int idx = {msb(a,i), msb(b,i)};
      r[63-i] = msb(c, base + idx);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [63:0] d, a, b, c,
                        input logic [7:0] t, input logic nh, rec, so, input string req);
    logic [63:0] e;
    logic rec_ok;
    @(negedge clk);
    in_valid = 1; op = o; src_d = d; src_a = a; src_b = b; src_c = c;
    tt_imm = t; nh_sel = nh; rec_en = rec; so_in = so;
    case (o)
      2'd0: e = m_xpose(a);
      2'd1: e = m_tern(d, a, b, t);
      2'd2: e = m_bin(a, b, c, nh);
      default: e = '0;
    endcase
    rec_ok = rec && (o == 2'd0 || o == 2'd1);
    if (rec_ok) begin
      logic signed [63:0] s = e;
      cr_model = {s < 0, s > 0, s == 0, so};
    end
    res_model = e;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, result, e);
    chk(rec_ok ? "R6 cr_valid" : (o == 2'd2 ? "R7 cr_valid" : "R8 cr_valid"),
        {63'd0, cr_valid}, {63'd0, rec_ok});
    chk(rec_ok ? "R6 cr_out" : "R7 R8 cr_out held", {60'd0, cr_out}, {60'd0, cr_model});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 cr", {59'd0, cr_valid, cr_out}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {59'd0, out_valid, cr_out}, 64'd0);

    // R3 directed: single bit and row patterns
    run_op(2'd0, 0, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 1, 1, "R3 corner");
    run_op(2'd0, 0, 64'hFF00_0000_0000_0000, 0, 0, 0, 0, 1, 0, "R3 row");
    run_op(2'd0, 0, 64'h0000_0000_0000_0001, 0, 0, 0, 0, 1, 0, "R3 last");
    run_op(2'd0, 0, 64'h0, 0, 0, 0, 0, 1, 1, "R3 zero EQ");
    // R4 directed: majority, pure-bit tables, zero table
    run_op(2'd1, 64'hF0F0, 64'hCCCC, 64'hAAAA, 0, 8'hE8, 0, 1, 0, "R4 majority");
    run_op(2'd1, 64'hF0F0, 64'hCCCC, 64'hAAAA, 0, 8'h80, 0, 1, 0, "R4 idx0");
    run_op(2'd1, 64'hF0F0, 64'hCCCC, 64'hAAAA, 0, 8'h01, 0, 1, 1, "R4 idx7");
    run_op(2'd1, -64'sd1, -64'sd1, -64'sd1, 0, 8'h00, 0, 1, 1, "R4 zero EQ");
    run_op(2'd1, 64'h0, 64'h0, 64'h0, 0, 8'h80, 0, 1, 0, "R4 all ones LT");
    // R5 directed: both nibbles, distinct tables
    run_op(2'd2, 0, 64'hFF00, 64'hF0F0, 64'h0000_0000_0000_00E8, 0, 0, 1, 0, "R5 low nibble");
    run_op(2'd2, 0, 64'hFF00, 64'hF0F0, 64'h0000_0000_0000_00E8, 0, 1, 1, 0, "R5 high nibble");
    // R7 two-input with record flag
    run_op(2'd2, 0, -64'sd1, -64'sd1, 64'h1, 0, 0, 1, 1, "R7 bin rec");
    // R9 reserved
    run_op(2'd3, -64'sd1, -64'sd1, -64'sd1, -64'sd1, 8'hFF, 1, 1, 1, "R9 reserved");

    // R2 hold across idle cycles
    repeat (3) @(negedge clk);
    chk("R2 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R2 hold", result, res_model);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] o = 2'($urandom_range(0, 3));
      logic [63:0] d = {$urandom, $urandom};
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [63:0] c = {$urandom, $urandom};
      string tag;
      case (o)
        2'd0: tag = "R3 rand";
        2'd1: tag = "R4 rand";
        2'd2: tag = "R5 rand";
        default: tag = "R9 rand";
      endcase
      run_op(o, d, a, b, c, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), tag);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule